// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the per-endpoint control and status registers of a full-speed USB device controller. Each endpoint has one 16-bit register. The bits in that register follow four different write rules. Completion flags are cleared by writing zero. Data-toggle bits and handshake status bits flip when a one is written to them. Configuration fields are ordinary read/write bits. Because of these rules, software can change one field with a single write. It never has to read, modify and write back flags that the hardware may be setting at the same moment.

A CPU register port reads and writes the bank, and it accepts only halfword accesses. A USB engine port reports finished transactions. For each finished transaction the bank sets the endpoint's completion flag, flips its data toggle and parks its handshake status at NAK, all in a single cycle. A combined interrupt output is raised while any completion flag is pending. It reports the lowest-numbered endpoint that has a pending flag.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: Register n sits at byte address 4*n, so `cpu_addr[4:2]` selects the register and `cpu_addr[1:0]` must be 0. An access is accepted only when `cpu_size` is 2'b01 (halfword). A write with any other size, or with a misaligned address, changes nothing. For an accepted access with `cpu_sel` high, `cpu_rdata` shows the selected register combinationally. In every other case `cpu_rdata` is 0.
- R2: After reset every register reads 0, `irq` is low and `irq_ep` is 0.
- R3: The receive completion flag (bit 15) and the transmit completion flag (bit 7) are cleared by a CPU write of 0 to that bit. Writing 1 to either bit leaves it unchanged.
- R4: The receive data toggle (bit 14) and the transmit data toggle (bit 6) flip when the CPU writes 1 to them. Writing 0 leaves them unchanged.
- R5: The receive status field (bits 13:12) and the transmit status field (bits 5:4) flip bit by bit wherever the CPU writes a 1. The status codes are 00 disabled, 01 stall, 10 NAK and 11 valid.
- R6: The endpoint type (bits 10:9), the kind bit (bit 8) and the endpoint address (bits 3:0) take the written value on every accepted write.
- R7: Bit 11 (setup marker) cannot be changed by a CPU write. A receive completion loads it with `eng_setup`. A transmit completion leaves it unchanged.
- R8: A pulse on `eng_done` reports a finished transaction on endpoint `eng_ep`, where `eng_dir` 0 means receive and 1 means transmit. At the next clock edge the bank sets that direction's completion flag, flips its data toggle and sets its status to NAK (2'b10). All other fields and all other endpoints stay unchanged.
- R9: A CPU write and an engine completion can hit the same register in the same cycle. In that case the completion flag ends up set even if the CPU wrote 0 to it. The data toggle takes both flips. The status ends at NAK whatever value the CPU wrote.
- R10: `irq` is high exactly while some register has bit 15 or bit 7 set. `irq_ep` then gives the lowest such register index, and it is 0 while `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 5 | CPU byte address |
| cpu_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| eng_done | input | 1 | Engine transaction-complete pulse |
| eng_ep | input | 3 | Endpoint of the finished transaction |
| eng_dir | input | 1 | 0 receive, 1 transmit |
| eng_setup | input | 1 | Finished receive was a setup transaction |
| irq | output | 1 | Some completion flag is pending |
| irq_ep | output | 3 | Lowest endpoint with a pending flag |

## Verification
Reset release passes through a two-stage synchronizer, so the bench waits several edges after `rst_n` rises before it drives anything. CPU writes and engine events are applied with a one-cycle pulse. The bench drives them one time unit after a rising edge, and they take effect at the next rising edge. Read data, `irq` and `irq_ep` follow the registers combinationally, so the bench checks them after that edge and before the next one. The bench model is updated at the same edge, using rules written from the requirements. Every check then compares a combinational readback against that model, with no extra latency to account for.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int REG_W    = 16;
  localparam int B_CRX    = 15;
  localparam int B_TRX    = 14;
  localparam int B_SRX_HI = 13;
  localparam int B_SRX_LO = 12;
  localparam int B_SETUP  = 11;
  localparam int B_TYP_HI = 10;
  localparam int B_TYP_LO = 9;
  localparam int B_KIND   = 8;
  localparam int B_CTX    = 7;
  localparam int B_TTX    = 6;
  localparam int B_STX_HI = 5;
  localparam int B_STX_LO = 4;
  localparam int B_EA_HI  = 3;
  localparam int B_EA_LO  = 0;

  typedef enum logic [1:0] {
    HS_OFF   = 2'b00,
    HS_STALL = 2'b01,
    HS_NAK   = 2'b10,
    HS_VALID = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             evt_rx,
  input  logic             evt_tx,
  input  logic             evt_setup,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] nxt;
  logic             upd_en;

  assign upd_en = wr_en | evt_rx | evt_tx;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      nxt[B_CRX]             = q[B_CRX] & wdata[B_CRX];
      nxt[B_CTX]             = q[B_CTX] & wdata[B_CTX];
      nxt[B_TRX]             = q[B_TRX] ^ wdata[B_TRX];
      nxt[B_TTX]             = q[B_TTX] ^ wdata[B_TTX];
      nxt[B_SRX_HI:B_SRX_LO] = q[B_SRX_HI:B_SRX_LO] ^ wdata[B_SRX_HI:B_SRX_LO];
      nxt[B_STX_HI:B_STX_LO] = q[B_STX_HI:B_STX_LO] ^ wdata[B_STX_HI:B_STX_LO];
      nxt[B_TYP_HI:B_TYP_LO] = wdata[B_TYP_HI:B_TYP_LO];
      nxt[B_KIND]            = wdata[B_KIND];
      nxt[B_EA_HI:B_EA_LO]   = wdata[B_EA_HI:B_EA_LO];
    end
    if (evt_rx) begin
      nxt[B_CRX]             = 1'b1;
      nxt[B_TRX]             = ~nxt[B_TRX];
      nxt[B_SRX_HI:B_SRX_LO] = HS_NAK;
      nxt[B_SETUP]           = evt_setup;
    end
    if (evt_tx) begin
      nxt[B_CTX]             = 1'b1;
      nxt[B_TTX]             = ~nxt[B_TTX];
      nxt[B_STX_HI:B_STX_LO] = HS_NAK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd_en) begin
      q <= nxt;
    end
  end

  // R3: pending flags survive cycles with no write and no event
  a_r3_crx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !evt_rx && q[B_CRX]) |=> q[B_CRX]);
  a_r3_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !evt_tx && q[B_CTX]) |=> q[B_CTX]);
  // R4: a written one flips the receive toggle
  a_r4_trx_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_TRX] && !evt_rx) |=> (q[B_TRX] != $past(q[B_TRX])));
  // R7: CPU cannot move the setup marker
  a_r7_setup_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !evt_rx) |=> $stable(q[B_SETUP]));
  // R8: completion parks status at NAK
  a_r8_nak_rx: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx |=> (q[B_SRX_HI:B_SRX_LO] == HS_NAK));
  a_r8_nak_tx: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx |=> (q[B_STX_HI:B_STX_LO] == HS_NAK));
  // R9: engine set beats a same-cycle clear
  a_r9_set_wins_rx: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx |=> q[B_CRX]);
  a_r9_set_wins_tx: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx |=> q[B_CTX]);
endmodule

// File: rtl/ep_pend_arb.sv
module ep_pend_arb #(
  parameter int N_EP = 8,
  localparam int IW  = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic [N_EP-1:0] pend,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = N_EP - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import ep_bank_pkg::*;
#(
  parameter int N_EP   = 8,
  parameter int STRIDE = 4,
  localparam int IW    = (N_EP > 1) ? $clog2(N_EP) : 1,
  localparam int SW    = $clog2(STRIDE),
  localparam int AW    = IW + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_sel,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [1:0]       cpu_size,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             eng_done,
  input  logic [IW-1:0]    eng_ep,
  input  logic             eng_dir,
  input  logic             eng_setup,
  output logic             irq,
  output logic [IW-1:0]    irq_ep
);
  logic [1:0]       rst_sync;
  logic             rst_q;
  logic             acc_ok;
  logic [IW-1:0]    sel_idx;
  logic [REG_W-1:0] regs [N_EP];
  logic [N_EP-1:0]  pend;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  assign sel_idx = cpu_addr[AW-1:SW];
  assign acc_ok  = cpu_sel && (cpu_size == SZ_HALF) &&
                   (cpu_addr[SW-1:0] == '0) && (int'(sel_idx) < N_EP);

  for (genvar g = 0; g < N_EP; g++) begin : g_slot
    logic hit_wr, hit_rx, hit_tx;
    assign hit_wr = acc_ok && cpu_we && (sel_idx == IW'(g));
    assign hit_rx = eng_done && !eng_dir && (eng_ep == IW'(g));
    assign hit_tx = eng_done &&  eng_dir && (eng_ep == IW'(g));

    ep_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_q),
      .wr_en     (hit_wr),
      .wdata     (cpu_wdata),
      .evt_rx    (hit_rx),
      .evt_tx    (hit_tx),
      .evt_setup (eng_setup),
      .q         (regs[g])
    );
    assign pend[g] = regs[g][B_CRX] | regs[g][B_CTX];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < N_EP; i++) begin
      if (acc_ok && (sel_idx == IW'(i))) cpu_rdata = regs[i];
    end
  end

  ep_pend_arb #(.N_EP(N_EP)) u_arb (
    .pend (pend),
    .any  (irq),
    .idx  (irq_ep)
  );

  // R10: reported endpoint really has a pending flag
  a_r10_ep_pending: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> pend[irq_ep]);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_q)
    !irq |-> (irq_ep == '0));
  // R1: a rejected write with no engine event leaves the bank unchanged
  a_r1_reject_write: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_sel && cpu_we && (cpu_size != SZ_HALF) && !eng_done) |=> $stable(pend));
endmodule

// File: tb/tb_usb_ep_ctrl_bank.sv
module tb_usb_ep_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_sel, cpu_we, eng_done, eng_dir, eng_setup;
  logic [4:0]  cpu_addr;
  logic [1:0]  cpu_size;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [2:0]  eng_ep, irq_ep;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [8];

  always #10 clk = ~clk;

  usb_ep_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .eng_done(eng_done), .eng_ep(eng_ep),
    .eng_dir(eng_dir), .eng_setup(eng_setup), .irq(irq), .irq_ep(irq_ep)
  );

  function automatic logic [15:0] step(logic [15:0] r, bit wr, logic [15:0] w,
                                       bit erx, bit etx, bit es);
    logic [15:0] n = r;
    if (wr) begin
      n[15]    = r[15] & w[15];
      n[7]     = r[7] & w[7];
      n[14]    = r[14] ^ w[14];
      n[6]     = r[6] ^ w[6];
      n[13:12] = r[13:12] ^ w[13:12];
      n[5:4]   = r[5:4] ^ w[5:4];
      n[10:8]  = w[10:8];
      n[3:0]   = w[3:0];
    end
    if (erx) begin n[15] = 1'b1; n[14] = ~n[14]; n[13:12] = 2'b10; n[11] = es; end
    if (etx) begin n[7] = 1'b1; n[6] = ~n[6]; n[5:4] = 2'b10; end
    return n;
  endfunction

  task automatic idle();
    cpu_sel = 0; cpu_we = 0; cpu_addr = '0; cpu_size = 2'b01; cpu_wdata = '0;
    eng_done = 0; eng_ep = '0; eng_dir = 0; eng_setup = 0;
  endtask

  task automatic do_op(bit sel, bit we, logic [4:0] a, logic [1:0] sz, logic [15:0] w,
                       bit ed, logic [2:0] ee, bit edir, bit es);
    cpu_sel = sel; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = w;
    eng_done = ed; eng_ep = ee; eng_dir = edir; eng_setup = es;
    @(posedge clk);
    for (int e = 0; e < 8; e++) begin
      bit hw = sel && we && sz == 2'b01 && a[1:0] == 2'b00 && int'(a[4:2]) == e;
      bit hr = ed && !edir && int'(ee) == e;
      bit ht = ed && edir && int'(ee) == e;
      model[e] = step(model[e], hw, w, hr, ht, es);
    end
    #1 idle();
  endtask

  task automatic check_reg(int e, string tag);
    cpu_sel = 1; cpu_we = 0; cpu_size = 2'b01; cpu_addr = {3'(e), 2'b00};
    #1;
    checks++;
    if (cpu_rdata !== model[e]) begin
      errors++;
      $display("FAIL %s ep%0d: actual=%h expected=%h", tag, e, cpu_rdata, model[e]);
    end
    cpu_sel = 0;
  endtask

  task automatic check_irq(string tag);
    bit ex = 0; logic [2:0] ei = '0;
    for (int e = 7; e >= 0; e--) if (model[e][15] | model[e][7]) begin ex = 1; ei = 3'(e); end
    checks++;
    if (irq !== ex || irq_ep !== ei) begin
      errors++;
      $display("FAIL %s irq: actual=%b/%0d expected=%b/%0d", tag, irq, irq_ep, ex, ei);
    end
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int e = 0; e < 8; e++) model[e] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R2 reset state
    for (int e = 0; e < 8; e++) check_reg(e, "R2 reset");
    check_irq("R2 reset");

    // R6 plain fields
    do_op(1, 1, 5'd8, 2'b01, 16'h8285, 0, 0, 0, 0);
    check_reg(2, "R6 rw fields");
    // R8 receive completion with setup, R10 report
    do_op(0, 0, 0, 2'b01, 0, 1, 3'd2, 0, 1);
    check_reg(2, "R8 rx event"); check_reg(3, "R8 neighbour"); check_irq("R10 ep2");
    do_op(0, 0, 0, 2'b01, 0, 1, 3'd5, 1, 0);
    check_reg(5, "R8 tx event"); check_irq("R10 lowest");
    // R3 clear receive flag by writing zero
    do_op(1, 1, 5'd8, 2'b01, 16'h0080, 0, 0, 0, 0);
    check_reg(2, "R3 clear"); check_irq("R10 moves to ep5");
    // R4 and R5 flips
    do_op(1, 1, 5'd8, 2'b01, 16'h70C0, 0, 0, 0, 0);
    check_reg(2, "R4 R5 flip");
    // R7 setup marker read-only
    do_op(1, 1, 5'd8, 2'b01, 16'h0880, 0, 0, 0, 0);
    check_reg(2, "R7 setup ro");
    do_op(1, 1, 5'd8, 2'b01, 16'h0080, 0, 0, 0, 0);
    check_reg(2, "R7 setup ro zero");
    // R9 collision on ep5 tx
    do_op(1, 1, 5'd20, 2'b01, 16'h0050, 1, 3'd5, 1, 0);
    check_reg(5, "R9 collision"); check_irq("R9 irq");
    // R1 rejected accesses
    do_op(1, 1, 5'd12, 2'b10, 16'hFFFF, 0, 0, 0, 0);
    check_reg(3, "R1 word size");
    do_op(1, 1, 5'd13, 2'b01, 16'hFFFF, 0, 0, 0, 0);
    check_reg(3, "R1 misaligned");
    cpu_sel = 1; cpu_we = 0; cpu_addr = 5'd20; cpu_size = 2'b00; #1;
    checks++;
    if (cpu_rdata !== 16'h0) begin
      errors++; $display("FAIL R1 byte read: actual=%h expected=0000", cpu_rdata);
    end
    idle();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k = int'($urandom_range(0, 7));
      bit sel = ($urandom_range(0, 3) != 0);
      logic [1:0] sz = ($urandom_range(0, 3) != 0) ? 2'b01 : 2'($urandom_range(0, 3));
      logic [1:0] lo = ($urandom_range(0, 7) != 0) ? 2'b00 : 2'($urandom_range(0, 3));
      logic [15:0] w = 16'($urandom);
      bit ed = $urandom_range(0, 1) == 1;
      logic [2:0] ee = ($urandom_range(0, 1) == 1) ? 3'(k) : 3'($urandom_range(0, 7));
      do_op(sel, 1, {3'(k), lo}, sz, w, ed, ee, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)));
      check_reg(k, "R3 R4 R5 R6 R9 random");
      check_reg(int'(ee), "R8 random event");
      check_irq("R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule